// File: doc/BRIEF.md
# Frame-Format Control Register Bank

This block sits behind the deframer of a sensor-bus slave node. It receives one long command word at a time, tagged with the format the command arrived in, and compares the word with the node's programmed address. When the word carries the format-control code, it reads or writes one of eight 4-bit frame-format registers. It then builds the long response word that the node returns on the bus.

The bank holds the CRC polynomial, the CRC seed, the CRC length and the short-word data length, plus a selection register. The frame parameters the rest of the node uses are taken from this block's outputs. While the selection register holds all ones, those outputs are the programmed register values. Otherwise they are the fixed standard defaults. Bit-level signalling and CRC arithmetic belong to neighbouring blocks.

Top module: `fmtc_ctrl`

## Requirements
- R1: After reset the bank holds its defaults (polynomial 8'h01, seed 8'h0A, CRC length 4, short length 8, selection 0), the outputs show the standard defaults and `rsp_valid` is low.
- R2: A command executes only when its code field `cmd_word[3:0]` equals 4'b1010. Any other code leaves the registers unchanged and produces no response.
- R3: A command executes only when its address field `cmd_word[7:4]` equals `node_addr` or equals the global address 4'b0000. Any other address is ignored.
- R4: A command executes only when `cmd_fmt` is standard long (2'd1) or enhanced long (2'd2). Short (2'd0) and other (2'd3) are ignored.
- R5: The command word is laid out as {rw[15], index[14:12], data[11:8], address[7:4], code[3:0]}. When rw=1, data is written into the register at index. When rw=0, that register is read. The index map is: 0 polynomial high nibble, 1 polynomial low nibble, 2 seed high nibble, 3 seed low nibble, 4 CRC length, 5 short length, 6 reserved, 7 selection.
- R6: An accepted command to the node's own address raises `rsp_valid` for exactly one cycle, in the cycle after the command. An accepted global-address command executes but raises no response.
- R7: The response word is {rw, index, data, address, 4'b0000}. Its data field is the command's data on a write and the register contents on a read.
- R8: A write of a value greater than 8 to the CRC length register is dropped, and the register keeps its old value.
- R9: A write of a value less than 8 to the short length register is dropped, and the register keeps its old value.
- R10: The reserved register always reads 0, and writes to it have no effect.
- R11: While the selection register holds 4'hF, the `act_*` outputs carry the programmed registers. For any other value they carry the standard defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | A deframed command word is present this cycle |
| cmd_word | input | 16 | Long command word |
| cmd_fmt | input | 2 | Command format: 0 short, 1 standard long, 2 enhanced long, 3 other |
| node_addr | input | 4 | Programmed address of the node |
| rsp_valid | output | 1 | One-cycle strobe marking a response word |
| rsp_word | output | 16 | Long response word |
| act_poly | output | 8 | Active CRC polynomial |
| act_seed | output | 8 | Active CRC seed |
| act_crc_len | output | 4 | Active CRC length |
| act_short_len | output | 4 | Active short-word data length |

## Verification
A command is sampled at one rising edge. The register update and the response registers both take effect at that same edge. So `rsp_valid`, `rsp_word` and all `act_*` outputs are due one cycle after the command is presented. The bench drives each command on a falling edge, releases it on the next falling edge, and samples every result at that second falling edge. That point lies half a cycle after the edge that produced the results. Effects that cannot be seen directly, such as dropped writes and ignored commands, are confirmed by a read command afterwards and by the absence of `rsp_valid` in the cycle that is due.

// File: rtl/fmtc_pkg.sv
package fmtc_pkg;
    localparam int NIB_W    = 4;
    localparam int IDX_W    = 3;
    localparam int NUM_REGS = 1 << IDX_W;
    localparam int WORD_W   = 1 + IDX_W + 3 * NIB_W;

    localparam logic [NIB_W-1:0] CODE_FMT    = 4'b1010;
    localparam logic [NIB_W-1:0] ADDR_GLOBAL = 4'b0000;
    localparam logic [NIB_W-1:0] SEL_PROG    = 4'b1111;
    localparam logic [NIB_W-1:0] CRC_LEN_MAX = 4'd8;
    localparam logic [NIB_W-1:0] SHORT_MIN   = 4'd8;

    localparam int IX_POLY_HI = 0;
    localparam int IX_POLY_LO = 1;
    localparam int IX_SEED_HI = 2;
    localparam int IX_SEED_LO = 3;
    localparam int IX_CRC_LEN = 4;
    localparam int IX_SHORT   = 5;
    localparam int IX_RSVD    = 6;
    localparam int IX_SEL     = 7;

    typedef enum logic [1:0] {
        FMT_SHORT    = 2'd0,
        FMT_STD_LONG = 2'd1,
        FMT_ENH_LONG = 2'd2,
        FMT_OTHER    = 2'd3
    } cmd_fmt_e;

    typedef struct packed {
        logic             rw;
        logic [IDX_W-1:0] idx;
        logic [NIB_W-1:0] data;
        logic [NIB_W-1:0] addr;
        logic [NIB_W-1:0] code;
    } cmd_word_t;

    typedef struct packed {
        logic             reply;
        logic             wr;
        logic [IDX_W-1:0] idx;
        logic [NIB_W-1:0] data;
        logic [NIB_W-1:0] addr;
    } op_t;

    function automatic logic value_legal(input int index, input logic [NIB_W-1:0] v);
        case (index)
            IX_CRC_LEN: value_legal = (v <= CRC_LEN_MAX);
            IX_SHORT:   value_legal = (v >= SHORT_MIN);
            IX_RSVD:    value_legal = 1'b0;
            default:    value_legal = 1'b1;
        endcase
    endfunction
endpackage

// File: rtl/fmtc_decode.sv
module fmtc_decode
    import fmtc_pkg::*;
(
    input  logic              cmd_valid,
    input  logic [WORD_W-1:0] cmd_word,
    input  logic [1:0]        cmd_fmt,
    input  logic [NIB_W-1:0]  node_addr,
    output logic              exec,
    output logic              wen,
    output op_t               op
);
    cmd_word_t w;
    cmd_fmt_e  fmt;
    logic      fmt_ok, addr_ok, is_global;

    always_comb begin
        w         = cmd_word_t'(cmd_word);
        fmt       = cmd_fmt_e'(cmd_fmt);
        fmt_ok    = (fmt == FMT_STD_LONG) || (fmt == FMT_ENH_LONG);
        is_global = (w.addr == ADDR_GLOBAL);
        addr_ok   = is_global || (w.addr == node_addr);
        exec      = cmd_valid && fmt_ok && addr_ok && (w.code == CODE_FMT);
        wen       = exec && w.rw;
        op.reply  = exec && !is_global;
        op.wr     = w.rw;
        op.idx    = w.idx;
        op.data   = w.data;
        op.addr   = w.addr;
    end
endmodule

// File: rtl/fmtc_regbank.sv
module fmtc_regbank
    import fmtc_pkg::*;
#(
    parameter logic [7:0]       DEF_POLY      = 8'h01,
    parameter logic [7:0]       DEF_SEED      = 8'h0A,
    parameter logic [NIB_W-1:0] DEF_CRC_LEN   = 4'd4,
    parameter logic [NIB_W-1:0] DEF_SHORT_LEN = 4'd8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wen,
    input  logic [IDX_W-1:0]                 idx,
    input  logic [NIB_W-1:0]                 data,
    output logic [NUM_REGS-1:0][NIB_W-1:0]   regs_q
);
    localparam logic [NUM_REGS-1:0][NIB_W-1:0] RST_VAL =
        {4'h0, 4'h0, DEF_SHORT_LEN, DEF_CRC_LEN,
         DEF_SEED[3:0], DEF_SEED[7:4], DEF_POLY[3:0], DEF_POLY[7:4]};

    typedef struct packed {
        logic [NUM_REGS-1:0][NIB_W-1:0] regs;
    } bank_t;

    bank_t               st_d, st_q;
    logic [NUM_REGS-1:0] hit;

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_hit
        assign hit[i] = wen && (idx == IDX_W'(i)) && value_legal(i, data);
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (hit[i]) st_d.regs[i] = data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= bank_t'(RST_VAL);
        else        st_q <= st_d;
    end

    assign regs_q = st_q.regs;
endmodule

// File: rtl/fmtc_respond.sv
module fmtc_respond
    import fmtc_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst_n,
    input  op_t                            op,
    input  logic [NUM_REGS-1:0][NIB_W-1:0] regs_q,
    output logic                           rsp_valid,
    output logic [WORD_W-1:0]              rsp_word
);
    typedef struct packed {
        logic              valid;
        logic [WORD_W-1:0] word;
    } rsp_t;

    rsp_t      st_d, st_q;
    cmd_word_t r;

    always_comb begin
        r.rw   = op.wr;
        r.idx  = op.idx;
        r.data = op.wr ? op.data : regs_q[op.idx];
        r.addr = op.addr;
        r.code = '0;
        st_d.valid = op.reply;
        st_d.word  = op.reply ? WORD_W'(r) : st_q.word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid = st_q.valid;
    assign rsp_word  = st_q.word;
endmodule

// File: rtl/fmtc_select.sv
module fmtc_select
    import fmtc_pkg::*;
#(
    parameter logic [7:0]       DEF_POLY      = 8'h01,
    parameter logic [7:0]       DEF_SEED      = 8'h0A,
    parameter logic [NIB_W-1:0] DEF_CRC_LEN   = 4'd4,
    parameter logic [NIB_W-1:0] DEF_SHORT_LEN = 4'd8
) (
    input  logic [NIB_W-1:0] poly_hi,
    input  logic [NIB_W-1:0] poly_lo,
    input  logic [NIB_W-1:0] seed_hi,
    input  logic [NIB_W-1:0] seed_lo,
    input  logic [NIB_W-1:0] crc_len,
    input  logic [NIB_W-1:0] short_len,
    input  logic [NIB_W-1:0] sel,
    output logic [7:0]       act_poly,
    output logic [7:0]       act_seed,
    output logic [NIB_W-1:0] act_crc_len,
    output logic [NIB_W-1:0] act_short_len
);
    always_comb begin
        if (sel == SEL_PROG) begin
            act_poly      = {poly_hi, poly_lo};
            act_seed      = {seed_hi, seed_lo};
            act_crc_len   = crc_len;
            act_short_len = short_len;
        end else begin
            act_poly      = DEF_POLY;
            act_seed      = DEF_SEED;
            act_crc_len   = DEF_CRC_LEN;
            act_short_len = DEF_SHORT_LEN;
        end
    end
endmodule

// File: rtl/fmtc_ctrl.sv
module fmtc_ctrl
    import fmtc_pkg::*;
#(
    parameter logic [7:0] DEF_POLY      = 8'h01,
    parameter logic [7:0] DEF_SEED      = 8'h0A,
    parameter logic [3:0] DEF_CRC_LEN   = 4'd4,
    parameter logic [3:0] DEF_SHORT_LEN = 4'd8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_valid,
    input  logic [15:0] cmd_word,
    input  logic [1:0]  cmd_fmt,
    input  logic [3:0]  node_addr,
    output logic        rsp_valid,
    output logic [15:0] rsp_word,
    output logic [7:0]  act_poly,
    output logic [7:0]  act_seed,
    output logic [3:0]  act_crc_len,
    output logic [3:0]  act_short_len
);
    logic                           exec, wen;
    op_t                            op;
    logic [NUM_REGS-1:0][NIB_W-1:0] regs_q;
    logic [NIB_W-1:0]               sel_q;

    fmtc_decode u_decode (
        .cmd_valid (cmd_valid),
        .cmd_word  (cmd_word),
        .cmd_fmt   (cmd_fmt),
        .node_addr (node_addr),
        .exec      (exec),
        .wen       (wen),
        .op        (op)
    );

    fmtc_regbank #(
        .DEF_POLY      (DEF_POLY),
        .DEF_SEED      (DEF_SEED),
        .DEF_CRC_LEN   (DEF_CRC_LEN),
        .DEF_SHORT_LEN (DEF_SHORT_LEN)
    ) u_regbank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wen    (wen),
        .idx    (op.idx),
        .data   (op.data),
        .regs_q (regs_q)
    );

    fmtc_respond u_respond (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (op),
        .regs_q    (regs_q),
        .rsp_valid (rsp_valid),
        .rsp_word  (rsp_word)
    );

    assign sel_q = regs_q[IX_SEL];

    fmtc_select #(
        .DEF_POLY      (DEF_POLY),
        .DEF_SEED      (DEF_SEED),
        .DEF_CRC_LEN   (DEF_CRC_LEN),
        .DEF_SHORT_LEN (DEF_SHORT_LEN)
    ) u_select (
        .poly_hi       (regs_q[IX_POLY_HI]),
        .poly_lo       (regs_q[IX_POLY_LO]),
        .seed_hi       (regs_q[IX_SEED_HI]),
        .seed_lo       (regs_q[IX_SEED_LO]),
        .crc_len       (regs_q[IX_CRC_LEN]),
        .short_len     (regs_q[IX_SHORT]),
        .sel           (sel_q),
        .act_poly      (act_poly),
        .act_seed      (act_seed),
        .act_crc_len   (act_crc_len),
        .act_short_len (act_short_len)
    );
endmodule

// File: rtl/fmtc_ctrl_chk.sv
module fmtc_ctrl_chk #(
    parameter logic [7:0] DEF_POLY      = 8'h01,
    parameter logic [7:0] DEF_SEED      = 8'h0A,
    parameter logic [3:0] DEF_CRC_LEN   = 4'd4,
    parameter logic [3:0] DEF_SHORT_LEN = 4'd8
) (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_valid,
    input logic [15:0] cmd_word,
    input logic [1:0]  cmd_fmt,
    input logic [3:0]  node_addr,
    input logic        exec,
    input logic        rsp_valid,
    input logic [15:0] rsp_word,
    input logic [7:0]  act_poly,
    input logic [7:0]  act_seed,
    input logic [3:0]  act_crc_len,
    input logic [3:0]  act_short_len,
    input logic [3:0]  sel_q
);
    assert_rsp_after_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(cmd_valid));

    assert_global_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_word[7:4] == 4'h0) |=> !rsp_valid);

    assert_foreign_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_word[7:4] != node_addr && cmd_word[7:4] != 4'h0) |=> !rsp_valid);

    assert_bad_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_word[3:0] != 4'b1010) |=> !rsp_valid);

    assert_bad_fmt_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_fmt == 2'd0 || cmd_fmt == 2'd3) |-> !exec);

    assert_rsp_zero_tail_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_word[3:0] == 4'h0));

    assert_crc_len_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        act_crc_len <= 4'd8);

    assert_short_len_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        act_short_len >= 4'd8);

    assert_quiet_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !exec |=> ($stable(act_poly) && $stable(act_seed) &&
                   $stable(act_crc_len) && $stable(act_short_len)));

    assert_default_active_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q != 4'hF) |-> (act_poly == DEF_POLY && act_seed == DEF_SEED &&
                             act_crc_len == DEF_CRC_LEN && act_short_len == DEF_SHORT_LEN));
endmodule

bind fmtc_ctrl fmtc_ctrl_chk #(
    .DEF_POLY      (DEF_POLY),
    .DEF_SEED      (DEF_SEED),
    .DEF_CRC_LEN   (DEF_CRC_LEN),
    .DEF_SHORT_LEN (DEF_SHORT_LEN)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_valid     (cmd_valid),
    .cmd_word      (cmd_word),
    .cmd_fmt       (cmd_fmt),
    .node_addr     (node_addr),
    .exec          (exec),
    .rsp_valid     (rsp_valid),
    .rsp_word      (rsp_word),
    .act_poly      (act_poly),
    .act_seed      (act_seed),
    .act_crc_len   (act_crc_len),
    .act_short_len (act_short_len),
    .sel_q         (sel_q)
);

// File: tb/fmtc_ctrl_test.sv
module fmtc_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [15:0] cmd_word = '0;
    logic [1:0]  cmd_fmt = 2'd1;
    logic [3:0]  node_addr = 4'h9;
    logic        rsp_valid;
    logic [15:0] rsp_word;
    logic [7:0]  act_poly, act_seed;
    logic [3:0]  act_crc_len, act_short_len;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    localparam logic [3:0] CODE = 4'b1010;
    localparam logic [3:0] ME   = 4'h9;

    always #2 clk = ~clk;

    fmtc_ctrl uut (
        .clk (clk), .rst_n (rst_n), .cmd_valid (cmd_valid), .cmd_word (cmd_word),
        .cmd_fmt (cmd_fmt), .node_addr (node_addr), .rsp_valid (rsp_valid),
        .rsp_word (rsp_word), .act_poly (act_poly), .act_seed (act_seed),
        .act_crc_len (act_crc_len), .act_short_len (act_short_len)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Present one command for one edge; return at the following falling edge.
    task automatic send(input logic rw, input logic [2:0] idx, input logic [3:0] data,
                        input logic [3:0] addr, input logic [3:0] code, input logic [1:0] fmt);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_word  = {rw, idx, data, addr, code};
        cmd_fmt   = fmt;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_word  = '0;
        cmd_fmt   = 2'd1;
    endtask

    task automatic expect_read(input string req, input logic [2:0] idx, input logic [3:0] val);
        send(1'b0, idx, 4'h0, ME, CODE, 2'd1);
        chk(req, {15'd0, rsp_valid}, 16'd1);
        chk(req, rsp_word, {1'b0, idx, val, ME, 4'h0});
    endtask

    task automatic t_reset;
        chk("R1", {15'd0, rsp_valid}, 16'd0);
        chk("R1", {8'd0, act_poly}, 16'h01);
        chk("R1", {8'd0, act_seed}, 16'h0A);
        chk("R1", {12'd0, act_crc_len}, 16'd4);
        chk("R1", {12'd0, act_short_len}, 16'd8);
        expect_read("R1", 3'd7, 4'h0);
        expect_read("R1", 3'd3, 4'hA);
    endtask

    task automatic t_write_read;
        send(1'b1, 3'd0, 4'h3, ME, CODE, 2'd1);
        chk("R7", {15'd0, rsp_valid}, 16'd1);
        chk("R7", rsp_word, {1'b1, 3'd0, 4'h3, ME, 4'h0});
        @(negedge clk);
        chk("R6", {15'd0, rsp_valid}, 16'd0);
        expect_read("R5", 3'd0, 4'h3);
        expect_read("R5", 3'd4, 4'd4);
    endtask

    task automatic t_bad_code;
        send(1'b1, 3'd0, 4'h5, ME, 4'b1011, 2'd1);
        chk("R2", {15'd0, rsp_valid}, 16'd0);
        expect_read("R2", 3'd0, 4'h3);
    endtask

    task automatic t_bad_addr;
        send(1'b1, 3'd0, 4'h6, 4'h5, CODE, 2'd1);
        chk("R3", {15'd0, rsp_valid}, 16'd0);
        expect_read("R3", 3'd0, 4'h3);
    endtask

    task automatic t_formats;
        send(1'b1, 3'd1, 4'h7, ME, CODE, 2'd0);
        chk("R4", {15'd0, rsp_valid}, 16'd0);
        send(1'b1, 3'd1, 4'h8, ME, CODE, 2'd3);
        chk("R4", {15'd0, rsp_valid}, 16'd0);
        expect_read("R4", 3'd1, 4'h1);
        send(1'b1, 3'd1, 4'hC, ME, CODE, 2'd2);
        chk("R4", {15'd0, rsp_valid}, 16'd1);
        expect_read("R4", 3'd1, 4'hC);
    endtask

    task automatic t_global;
        send(1'b1, 3'd3, 4'h7, 4'h0, CODE, 2'd1);
        chk("R6", {15'd0, rsp_valid}, 16'd0);
        expect_read("R6", 3'd3, 4'h7);
    endtask

    task automatic t_crc_len;
        send(1'b1, 3'd4, 4'd9, ME, CODE, 2'd1);
        chk("R8", rsp_word, {1'b1, 3'd4, 4'd9, ME, 4'h0});
        expect_read("R8", 3'd4, 4'd4);
        send(1'b1, 3'd4, 4'd8, ME, CODE, 2'd1);
        expect_read("R8", 3'd4, 4'd8);
        send(1'b1, 3'd4, 4'd15, ME, CODE, 2'd1);
        expect_read("R8", 3'd4, 4'd8);
        send(1'b1, 3'd4, 4'd0, ME, CODE, 2'd1);
        expect_read("R8", 3'd4, 4'd0);
    endtask

    task automatic t_short_len;
        send(1'b1, 3'd5, 4'd7, ME, CODE, 2'd1);
        expect_read("R9", 3'd5, 4'd8);
        send(1'b1, 3'd5, 4'd12, ME, CODE, 2'd1);
        expect_read("R9", 3'd5, 4'd12);
        send(1'b1, 3'd5, 4'd0, ME, CODE, 2'd1);
        expect_read("R9", 3'd5, 4'd12);
    endtask

    task automatic t_reserved;
        send(1'b1, 3'd6, 4'hF, ME, CODE, 2'd1);
        chk("R10", {15'd0, rsp_valid}, 16'd1);
        expect_read("R10", 3'd6, 4'h0);
    endtask

    task automatic t_select;
        send(1'b1, 3'd2, 4'h5, ME, CODE, 2'd1);
        chk("R11", {8'd0, act_seed}, 16'h0A);
        send(1'b1, 3'd7, 4'hE, ME, CODE, 2'd1);
        chk("R11", {8'd0, act_poly}, 16'h01);
        send(1'b1, 3'd7, 4'hF, ME, CODE, 2'd1);
        chk("R11", {8'd0, act_poly}, 16'h3C);
        chk("R11", {8'd0, act_seed}, 16'h57);
        chk("R11", {12'd0, act_crc_len}, 16'd0);
        chk("R11", {12'd0, act_short_len}, 16'd12);
        send(1'b1, 3'd7, 4'h7, ME, CODE, 2'd1);
        chk("R11", {8'd0, act_seed}, 16'h0A);
        chk("R11", {12'd0, act_crc_len}, 16'd4);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_write_read;
        t_bad_code;
        t_bad_addr;
        t_formats;
        t_global;
        t_crc_len;
        t_short_len;
        t_reserved;
        t_select;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule